// File: doc/BRIEF.md
# Ring Passthrough Reduction Forwarder

This block speeds up global reductions along one dimension of a torus of compute nodes. Once started, the node first sends its own contribution to the neighbour in the plus direction. Every value that then arrives from the minus-direction neighbour is forwarded to the plus-direction neighbour in the next cycle. The same value is also queued in a small local FIFO. The FIFO drains to local memory through a bus write master, one 64-bit word per granted cycle. Forwarding never waits for the bus.

On a ring of N nodes each node receives N-1 foreign values. These are written to consecutive 64-bit words of memory, starting at a programmed base address, in the order they arrived. A done flag then rises, and software adds the N contributions itself. A received value is passed on only while fewer than N-2 received values have been forwarded, so no value comes back round to the node that sent it. When the FIFO is full, the receive link is held off with backpressure and no data is lost. A sticky error bit records that the link was stalled this way.

Top module: `ring_fwd`

## Requirements
- R1: While no operation is in progress (after reset, or after done), `rxReady` stays low. A value offered on the receive link is not taken: nothing reaches `txValid` or `memReq`.
- R2: A one-cycle `cfgStart` pulse latches `cfgRingLen` (N, at least 2) and `cfgBase`. In the next cycle `txValid` is high and `txData` equals `ownValue`. This is the first value sent in the operation.
- R3: A received value accepted (`rxValid` and `rxReady` high at a clock edge) while fewer than N-2 received values have been accepted appears on `txData`, with `txValid` high, in the next cycle. Later accepted values are not forwarded, so one operation sends exactly N-1 values.
- R4: `memReq` is high whenever the FIFO holds data. A word is written only in a cycle where `memReq` and `memGrant` are both high. The k-th write (k from 0) has address `cfgBase + 8*k` and carries the k-th accepted value. Forwarding goes on even when no grant is given.
- R5: When the FIFO holds FIFO_DEPTH values, `rxReady` is low. Every value held back this way is accepted and written once space frees up.
- R6: `errOverflow` is set when `rxValid` is high while the FIFO is full during an operation. It stays set until the next `cfgStart`, which clears it.
- R7: After N-1 values have been accepted, `rxReady` stays low. The cycle after the (N-1)-th memory write, `done` goes high and stays high until the next `cfgStart`, which clears it.
- R8: While `txValid` is high and `txReady` is low, `txData` holds its value. A received value that would have to be forwarded is not accepted until the send slot frees up.
- R9: During and right after reset, `txValid`, `memReq`, `rxReady`, `done` and `errOverflow` are low.

Each value is DATA_W bits wide; `cfgBase` and `memAddr` are byte addresses of ADDR_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgStart | input | 1 | One-cycle pulse that starts a reduction |
| cfgRingLen | input | LEN_W | Ring length N, at least 2 |
| cfgBase | input | ADDR_W | Byte address of the first memory word |
| ownValue | input | DATA_W | This node's own contribution |
| rxValid | input | 1 | Minus-direction neighbour offers a value |
| rxData | input | DATA_W | Offered value |
| rxReady | output | 1 | Value is taken at this edge |
| txValid | output | 1 | Value offered to the plus-direction neighbour |
| txData | output | DATA_W | Offered value |
| txReady | input | 1 | Plus-direction neighbour takes the value |
| memReq | output | 1 | Write request to memory |
| memAddr | output | ADDR_W | Write byte address |
| memData | output | DATA_W | Write data |
| memGrant | input | 1 | Bus grants the write this cycle |
| done | output | 1 | All N-1 values written to memory |
| errOverflow | output | 1 | Sticky: receive link was stalled by a full FIFO |

## Verification
The bench builds the block with a 4-entry FIFO, 64-bit data, 32-bit addresses and an 8-bit ring length. With a FIFO that shallow, a ring of 8 nodes with the bus grant held off fills the queue within a few cycles. That brings backpressure, the sticky error and its clearing on restart within reach of short runs. Ring lengths 2 to 8, sparse grant patterns and a stalled send link show the forward cut-off at N-2 received values, forwarding that goes on without any grant, and in-order addressing.

// File: rtl/ring_fwd_pkg.sv
`timescale 1ns/1ps
package ring_fwd_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clear;      // discard queued state at the start of an operation
    logic injectOwn;  // load own value into the send slot
    logic pushRx;     // enqueue the accepted received value
    logic fwdRx;      // load the accepted received value into the send slot
    logic popMem;     // FIFO head is written to memory this cycle
  } dpStrobe_t;
endpackage

// File: rtl/ring_fwd_ctrl.sv
`timescale 1ns/1ps
module ring_fwd_ctrl
  import ring_fwd_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgStart,
  input  logic [LEN_W-1:0] cfgRingLen,
  input  logic             rxValid,
  input  logic             txReady,
  input  logic             memGrant,
  input  logic             txValid,
  input  logic             fifoFull,
  input  logic             fifoEmpty,
  output dpStrobe_t        strb,
  output logic             rxReady,
  output logic             memReq,
  output logic             active,
  output logic             done,
  output logic             errOverflow
);
  localparam int CW = LEN_W + 1;

  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] rxCnt;
  logic [LEN_W-1:0] wrCnt;
  logic             needFwd;
  logic             rxRoom;
  logic             txFree;
  logic             accept;
  logic             lastWrite;

  always_comb begin
    needFwd   = ({1'b0, rxCnt} + CW'(2)) < {1'b0, lenQ};
    rxRoom    = ({1'b0, rxCnt} + CW'(1)) < {1'b0, lenQ};
    txFree    = !txValid || txReady;
    rxReady   = active && !cfgStart && rxRoom && !fifoFull && (!needFwd || txFree);
    accept    = rxValid && rxReady;
    memReq    = !fifoEmpty;
    strb.clear     = cfgStart;
    strb.injectOwn = cfgStart;
    strb.pushRx    = accept;
    strb.fwdRx     = accept && needFwd;
    strb.popMem    = !fifoEmpty && memGrant && !cfgStart;
    lastWrite = strb.popMem && (({1'b0, wrCnt} + CW'(2)) == {1'b0, lenQ});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenQ        <= '0;
      rxCnt       <= '0;
      wrCnt       <= '0;
      active      <= 1'b0;
      done        <= 1'b0;
      errOverflow <= 1'b0;
    end else if (cfgStart) begin
      lenQ        <= cfgRingLen;
      rxCnt       <= '0;
      wrCnt       <= '0;
      active      <= 1'b1;
      done        <= 1'b0;
      errOverflow <= 1'b0;
    end else begin
      if (accept) rxCnt <= rxCnt + 1'b1;
      if (strb.popMem) wrCnt <= wrCnt + 1'b1;
      if (lastWrite) begin
        done   <= 1'b1;
        active <= 1'b0;
      end
      if (active && rxValid && fifoFull && rxRoom) errOverflow <= 1'b1;
    end
  end
endmodule

// File: rtl/ring_fwd_dp.sv
`timescale 1ns/1ps
module ring_fwd_dp
  import ring_fwd_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int ADDR_W     = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] ownValue,
  input  logic [DATA_W-1:0] rxData,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic              txReady,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              fifoFull,
  output logic              fifoEmpty
);
  localparam int PTR_W   = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);
  localparam int WORD_B  = DATA_W / 8;

  logic [DATA_W-1:0] store [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [CNT_W-1:0]  level;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign fifoFull  = (level == CNT_W'(FIFO_DEPTH));
  assign fifoEmpty = (level == '0);
  assign memData   = store[rdPtr];

  // queue storage, no reset needed
  always_ff @(posedge clk) begin
    if (strb.pushRx) store[wrPtr] <= rxData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (strb.pushRx) wrPtr <= nextPtr(wrPtr);
      if (strb.popMem) rdPtr <= nextPtr(rdPtr);
      case ({strb.pushRx, strb.popMem})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // running write address
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr <= '0;
    end else if (strb.clear) begin
      memAddr <= cfgBase;
    end else if (strb.popMem) begin
      memAddr <= memAddr + ADDR_W'(WORD_B);
    end
  end

  // send slot toward the plus-direction neighbour
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txData  <= '0;
    end else if (strb.injectOwn) begin
      txValid <= 1'b1;
      txData  <= ownValue;
    end else if (strb.fwdRx) begin
      txValid <= 1'b1;
      txData  <= rxData;
    end else if (txReady) begin
      txValid <= 1'b0;
    end
  end
endmodule

// File: rtl/ring_fwd.sv
`timescale 1ns/1ps
module ring_fwd
  import ring_fwd_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgStart,
  input  logic [LEN_W-1:0]  cfgRingLen,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [DATA_W-1:0] ownValue,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  input  logic              txReady,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  input  logic              memGrant,
  output logic              done,
  output logic              errOverflow
);
  dpStrobe_t strb;
  logic      fifoFull;
  logic      fifoEmpty;
  logic      active;

  ring_fwd_ctrl #(.LEN_W(LEN_W)) ctrl (
    .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .cfgRingLen(cfgRingLen),
    .rxValid(rxValid), .txReady(txReady), .memGrant(memGrant),
    .txValid(txValid), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .strb(strb), .rxReady(rxReady), .memReq(memReq), .active(active),
    .done(done), .errOverflow(errOverflow)
  );

  ring_fwd_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ownValue(ownValue), .rxData(rxData),
    .cfgBase(cfgBase), .txReady(txReady), .txValid(txValid), .txData(txData),
    .memAddr(memAddr), .memData(memData), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty)
  );
endmodule

// File: rtl/ring_fwd_chk.sv
`timescale 1ns/1ps
module ring_fwd_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgStart,
  input logic [DATA_W-1:0] ownValue,
  input logic              rxValid,
  input logic [DATA_W-1:0] rxData,
  input logic              rxReady,
  input logic              txValid,
  input logic [DATA_W-1:0] txData,
  input logic              txReady,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memGrant,
  input logic              done,
  input logic              errOverflow,
  input logic              active,
  input logic              fifoFull,
  input logic              fwdStrobe
);
  localparam int WORD_B = DATA_W / 8;

  a_r1_idle_no_ready: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !rxReady);

  a_r2_own_first: assert property (@(posedge clk) disable iff (!rstN)
    cfgStart |=> (txValid && txData == $past(ownValue)));

  a_r3_forward_next: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxReady && fwdStrobe) |=> (txValid && txData == $past(rxData)));

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memGrant && !cfgStart) |=> (!memReq || memAddr == $past(memAddr) + ADDR_W'(WORD_B)));

  a_r4_hold_without_grant: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGrant && !cfgStart) |=> (memReq && $stable(memAddr)));

  a_r5_no_take_when_full: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !rxReady);

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errOverflow && !cfgStart) |=> errOverflow);

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (done && !cfgStart) |=> done);

  a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !cfgStart) |=> (txValid && $stable(txData)));
endmodule

bind ring_fwd ring_fwd_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .ownValue(ownValue),
  .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady),
  .txValid(txValid), .txData(txData), .txReady(txReady),
  .memReq(memReq), .memAddr(memAddr), .memGrant(memGrant),
  .done(done), .errOverflow(errOverflow), .active(active),
  .fifoFull(fifoFull), .fwdStrobe(strb.fwdRx)
);

// File: tb/ring_fwd_test.sv
`timescale 1ns/1ps
module ring_fwd_test;
  localparam int DATA_W = 64;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 8;
  localparam int DEPTH  = 4;

  typedef struct packed {
    logic [7:0]  n;
    logic [31:0] base;
    logic [63:0] own;
    logic [63:0] seed;
    logic [3:0]  gap;
    logic [3:0]  hold;
    logic [7:0]  gDelay;
  } row_t;

  localparam int NROWS = 6;
  localparam row_t ROWS [NROWS] = '{
    '{8'd2, 32'h0000_1000, 64'hAAAA_0000_0000_0001, 64'h100, 4'd1, 4'd0, 8'd0},
    '{8'd3, 32'h0000_2000, 64'hAAAA_0000_0000_0002, 64'h200, 4'd1, 4'd0, 8'd0},
    '{8'd5, 32'h0000_0080, 64'hAAAA_0000_0000_0003, 64'h300, 4'd2, 4'd3, 8'd0},
    '{8'd4, 32'h0000_4000, 64'hAAAA_0000_0000_0004, 64'h400, 4'd1, 4'd0, 8'd20},
    '{8'd8, 32'h0000_0010, 64'hAAAA_0000_0000_0005, 64'h500, 4'd1, 4'd0, 8'd20},
    '{8'd5, 32'h0000_8000, 64'hAAAA_0000_0000_0006, 64'h600, 4'd3, 4'd0, 8'd0}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgStart = 1'b0;
  logic [LEN_W-1:0]  cfgRingLen = '0;
  logic [ADDR_W-1:0] cfgBase = '0;
  logic [DATA_W-1:0] ownValue = '0;
  logic              rxValid = 1'b0;
  logic [DATA_W-1:0] rxData = '0;
  logic              rxReady;
  logic              txValid;
  logic [DATA_W-1:0] txData;
  logic              txReady = 1'b1;
  logic              memReq;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memData;
  logic              memGrant = 1'b0;
  logic              done;
  logic              errOverflow;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ring_fwd #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .cfgRingLen(cfgRingLen),
    .cfgBase(cfgBase), .ownValue(ownValue), .rxValid(rxValid), .rxData(rxData),
    .rxReady(rxReady), .txValid(txValid), .txData(txData), .txReady(txReady),
    .memReq(memReq), .memAddr(memAddr), .memData(memData), .memGrant(memGrant),
    .done(done), .errOverflow(errOverflow)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runRow(input row_t r);
    int n, cyc, rxIdx, txCnt, memCnt, model, acc, fwd;
    logic expErr;
    logic finished;
    n = int'(r.n);
    rxIdx = 0; txCnt = 0; memCnt = 0; model = 0; expErr = 1'b0; finished = 1'b0;
    @(negedge clk);
    cfgRingLen = r.n; cfgBase = r.base; ownValue = r.own;
    cfgStart = 1'b1; rxValid = 1'b0; memGrant = 1'b0; txReady = 1'b1;
    @(negedge clk);
    cfgStart = 1'b0;
    cyc = 0;
    // cycle 0 sits one edge after start
    check("R7", "done cleared by start", 64'(done), 64'd0);
    check("R6", "error cleared by start", 64'(errOverflow), 64'd0);
    while (!finished) begin
      if (cyc > 0) @(negedge clk);
      memGrant = (cyc >= int'(r.gDelay)) && (((cyc - int'(r.gDelay)) % int'(r.gap)) == 0);
      txReady  = (cyc >= int'(r.hold));
      rxValid  = (rxIdx < n - 1);
      rxData   = r.seed + 64'(rxIdx);
      #1;
      if (memCnt == n - 1) begin
        check("R7", "done after last write", 64'(done), 64'd1);
        check("R7", "no take after N-1", 64'(rxReady), 64'd0);
        check("R3", "send count", 64'(txCnt), 64'(n - 1));
        check("R6", "error bit", 64'(errOverflow), 64'(expErr));
        rxValid = 1'b1;
        @(negedge clk); #1;
        check("R1", "idle ignores rx", 64'(rxReady), 64'd0);
        check("R1", "idle no send", 64'(txValid), 64'd0);
        check("R1", "idle no write", 64'(memReq), 64'd0);
        rxValid = 1'b0;
        finished = 1'b1;
      end else begin
        if (cyc < int'(r.hold)) begin
          check("R8", "send slot held", txData, r.own);
          check("R8", "send slot valid", 64'(txValid), 64'd1);
          if (n >= 3) check("R8", "rx blocked on busy slot", 64'(rxReady), 64'd0);
        end
        if (model == DEPTH) begin
          check("R5", "full queue blocks rx", 64'(rxReady), 64'd0);
          if (rxValid) expErr = 1'b1;
        end
        if (r.gDelay != 0 && cyc == int'(r.gDelay)) begin
          acc = (n - 1 < DEPTH) ? n - 1 : DEPTH;
          fwd = (acc < n - 2) ? acc : n - 2;
          check("R4", "forwarding without grant", 64'(txCnt), 64'(1 + fwd));
          check("R4", "no write without grant", 64'(memCnt), 64'd0);
        end
        if (txValid && txReady) begin
          if (txCnt == 0) check("R2", "own value first", txData, r.own);
          else check("R3", "forwarded value", txData, r.seed + 64'(txCnt - 1));
          txCnt++;
        end
        if (memReq && memGrant) begin
          check("R4", "write address", 64'(memAddr), 64'(r.base + 32'(8 * memCnt)));
          check("R4", "write data", memData, r.seed + 64'(memCnt));
          memCnt++;
          model--;
        end
        if (rxValid && rxReady) begin
          rxIdx++;
          model++;
        end
        cyc++;
        if (cyc > 400) begin
          check("R7", "operation timed out", 64'(memCnt), 64'(n - 1));
          finished = 1'b1;
        end
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R9", "reset txValid", 64'(txValid), 64'd0);
    check("R9", "reset memReq", 64'(memReq), 64'd0);
    check("R9", "reset rxReady", 64'(rxReady), 64'd0);
    check("R9", "reset done", 64'(done), 64'd0);
    check("R9", "reset error", 64'(errOverflow), 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    // R1: offered data before any start is not taken
    rxValid = 1'b1; rxData = 64'hDEAD;
    repeat (3) begin
      @(negedge clk); #1;
      check("R1", "no take before start", 64'(rxReady), 64'd0);
      check("R1", "no write before start", 64'(memReq), 64'd0);
      check("R1", "no send before start", 64'(txValid), 64'd0);
    end
    rxValid = 1'b0;

    for (int i = 0; i < NROWS; i++) runRow(ROWS[i]);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule